// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters from a processor into asynchronous serial frames on a single output line. A one-byte configuration word sets the frame format: character length of 5 to 8 bits, parity present or absent and its sense, stop length of 1, 1.5 or 2 bit times, and a clock factor of 1, 16 or 64 transmit-clock periods per bit. The transmit clock arrives as a one-cycle enable pulse, `tick`, in the system clock domain.

Characters are written into a holding register. On a tick, the waiting character moves into the shifter and the frame begins. This frees the holding register, so the next character can be written while the current one is still shifting out. Two status outputs report the state of the transmitter. `tx_rdy` is high while the holding register can accept a byte. `tx_empty` is high while there is neither a waiting character nor a frame on the line.

Top module: `ser_tx`

## Requirements
- R1: While reset is asserted, and until the first write after it, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A frame starts with one low start bit and then sends the data bits least significant bit first. The number of data bits is set by mode[3:2]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of the written byte are not sent.
- R3: When mode[4]=1, one parity bit follows the data bits. With mode[5]=1 the parity is even, so the data bits and the parity bit together hold an even number of ones. With mode[5]=0 the parity is odd. Parity is computed over the configured data bits only. When mode[4]=0, no parity bit is sent, whatever mode[5] holds.
- R4: mode[1:0] sets how many tick periods each start, data and parity bit lasts: 01 gives 1, 10 gives 16 and 11 gives 64. `txd` changes only on a clock edge where `tick` is 1.
- R5: The stop interval is high and its length is set by mode[7:6]. Code 01 gives 1 bit time. Code 11 gives 2 bit times. Code 10 gives 1.5 bit times, which is 24 ticks at factor 16, 96 ticks at factor 64, and 2 ticks at factor 1.
- R6: `tx_rdy` goes low in the cycle after a write. It goes high again after the tick edge on which the character moves into the shifter.
- R7: `tx_empty` is high only when the holding register is empty and no frame is in progress. It goes high after the tick edge that ends the last stop interval, and it implies `txd`=1.
- R8: If a character is waiting when a stop interval ends, its start bit begins on that same tick edge, with no idle time between the two frames.
- R9: The mode word is sampled when a character moves into the shifter. A mode change during a frame does not alter that frame.
- R10: When the transmitter is idle, a written character begins its start bit on the first tick edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 8 | Frame format word |
| tick | input | 1 | Transmit clock enable, one pulse per transmit-clock period |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output, idles high |
| tx_rdy | output | 1 | Holding register is free |
| tx_empty | output | 1 | Nothing waiting and nothing being sent |

## Verification
The bench covers these corner cases:

- **1.5-stop rounding at factor 1.** A design that fails to round would end the frame a tick early or send a fractional stop.
- **Parity on a 5-bit character whose unused upper bits are set.** A design that computes parity over the whole byte would flip the parity bit.
- **Parity disabled with the sense bit set.** A wrong design would emit a stray bit here.
- **Back-to-back characters.** A wrong design would insert an idle gap, or drop or repeat a character.
- **Mode word rewritten during a frame.** A design that reads the mode live would change bit widths or stop length partway through the frame.

Random mode words and data then cover the remaining combinations of factor, length, parity and stop.

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] mode,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t           st;
  logic [7:0]    hold;
  logic          full;
  logic [7:0]    cfg;
  logic [8:0]    sr;
  logic [3:0]    left;
  logic [CW-1:0] tcnt;

  logic [CW-1:0] unit, stop_len, cur_len;
  logic [3:0]    nchar;
  logic [7:0]    dch;
  logic          par, bit_end, load;

  assign unit = (cfg[1:0] == 2'b11) ? CW'(64) :
                (cfg[1:0] == 2'b10) ? CW'(16) : CW'(1);

  always_comb begin
    case (cfg[7:6])
      2'b10:   stop_len = (unit == CW'(1)) ? CW'(2) : unit + (unit >> 1);
      2'b11:   stop_len = unit << 1;
      default: stop_len = unit;
    endcase
  end

  assign cur_len = (st == S_STOP) ? stop_len : unit;
  assign bit_end = tick && (tcnt == cur_len - CW'(1));
  assign load    = tick && full && (st == S_IDLE || (st == S_STOP && bit_end));

  assign nchar = 4'd5 + {2'b00, mode[3:2]};
  assign dch   = wr_hold_mask(hold, mode[3:2]);
  assign par   = ^dch ^ ~mode[5];

  function automatic logic [7:0] wr_hold_mask(input logic [7:0] d, input logic [1:0] len);
    return d & (8'hFF >> (2'd3 - len));
  endfunction

  assign tx_rdy   = ~full;
  assign tx_empty = ~full && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hold <= '0;
      full <= 1'b0;
      cfg  <= '0;
      sr   <= '0;
      left <= '0;
      tcnt <= '0;
      txd  <= 1'b1;
    end else begin
      if (load) begin
        full <= 1'b0;
        cfg  <= mode;
        sr   <= {1'b0, dch} | (mode[4] ? (9'(par) << nchar) : 9'd0);
        left <= nchar + {3'b000, mode[4]};
        st   <= S_START;
        txd  <= 1'b0;
        tcnt <= '0;
      end else if (tick && st != S_IDLE) begin
        if (bit_end) begin
          tcnt <= '0;
          if (st == S_STOP) begin
            st <= S_IDLE;
          end else if (st == S_BITS && left == 4'd0) begin
            st  <= S_STOP;
            txd <= 1'b1;
          end else begin
            st   <= S_BITS;
            txd  <= sr[0];
            sr   <= sr >> 1;
            left <= left - 4'd1;
          end
        end else begin
          tcnt <= tcnt + CW'(1);
        end
      end
      if (wr_en) begin
        hold <= wr_data;
        full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_en,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty
);
  assert_line_steps_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  assert_write_takes_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_rdy);

  assert_slot_frees_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(tick));

  assert_empty_means_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_rdy);

  assert_empty_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_empty_drops_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);
endmodule

bind ser_tx ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
);

// File: tb/test_ser_tx.sv
module test_ser_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode = 8'h4D;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, tx_rdy, tx_empty;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  ser_tx i_ser_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int factor(input logic [7:0] m);
    return (m[1:0] == 2'b11) ? 64 : (m[1:0] == 2'b10) ? 16 : 1;
  endfunction

  task automatic gen(input logic [7:0] m, input logic [7:0] d);
    int f = factor(m);
    int n = 5 + int'(m[3:2]);
    int sl;
    bit p = 1'b0;
    for (int i = 0; i < f; i++) exp_q.push_back(1'b0);
    for (int b = 0; b < n; b++) begin
      p ^= d[b];
      for (int i = 0; i < f; i++) exp_q.push_back(d[b]);
    end
    if (m[4]) begin
      if (!m[5]) p = ~p;
      for (int i = 0; i < f; i++) exp_q.push_back(p);
    end
    case (m[7:6])
      2'b10:   sl = (f == 1) ? 2 : f + f / 2;
      2'b11:   sl = 2 * f;
      default: sl = f;
    endcase
    for (int i = 0; i < sl; i++) exp_q.push_back(1'b1);
  endtask

  task automatic do_tick(output bit s);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    s = txd;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    chk(tx_rdy == 1'b0, "R6 ready low after write", int'(tx_rdy), 0);
    chk(tx_empty == 1'b0, "R7 empty low after write", int'(tx_empty), 0);
  endtask

  // act: 0 none, 1 write act_val, 2 set mode to act_val, performed after sample act_at
  task automatic run_q(input int act, input int act_at, input logic [7:0] act_val, input string tag);
    int n = exp_q.size();
    int bad = 0;
    int first = -1;
    bit s;
    bit fs = 1'b0;
    for (int i = 0; i < n; i++) begin
      do_tick(s);
      if (s !== exp_q[i]) begin
        if (bad == 0) begin first = i; fs = s; end
        bad++;
      end
      if (i == 0) chk(tx_rdy == 1'b1, "R6 ready after load (R10)", int'(tx_rdy), 1);
      if (i == act_at && act == 1) write(act_val);
      if (i == act_at && act == 2) @(negedge clk) mode = act_val;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s tick %0d of %0d actual=%0d expected=%0d", tag, first, n, fs, exp_q[first]);
    end
    exp_q.delete();
    do_tick(s);
    chk(s == 1'b1, "R5 line high after frame", int'(s), 1);
    chk(tx_empty == 1'b1, "R7 empty after last stop", int'(tx_empty), 1);
  endtask

  task automatic frame(input logic [7:0] m, input logic [7:0] d, input string tag);
    @(negedge clk) mode = m;
    gen(m, d);
    write(d);
    run_q(0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] m, d, d2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", int'(txd), 1);
    chk(tx_rdy == 1'b1, "R1 ready in reset", int'(tx_rdy), 1);
    chk(tx_empty == 1'b1, "R1 empty in reset", int'(tx_empty), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1 && tx_rdy && tx_empty, "R1 idle after reset", int'({txd, tx_rdy, tx_empty}), 7);

    frame(8'b01_00_11_01, 8'h55, "R2 R4 8-bit 1x no parity");
    frame(8'b10_01_00_10, 8'hE3, "R3 R5 5-bit odd parity 1.5 stop 16x");
    frame(8'b11_11_10_11, 8'h3A, "R3 R5 7-bit even 2 stop 64x");
    frame(8'b10_11_00_01, 8'h1F, "R5 1.5 stop rounds to 2 at 1x");
    frame(8'b01_10_01_01, 8'hC6, "R3 parity off with sense bit set");
    frame(8'b01_11_00_10, 8'hFF, "R3 R2 5-bit even all ones");

    @(negedge clk) mode = 8'b01_01_01_10;
    gen(mode, 8'hA5);
    gen(mode, 8'h3C);
    write(8'hA5);
    run_q(1, 0, 8'h3C, "R8 back-to-back 16x");

    @(negedge clk) mode = 8'b11_11_11_01;
    gen(mode, 8'h96);
    write(8'h96);
    run_q(2, 3, 8'b10_00_00_11, "R9 mode change mid-frame");

    for (int k = 0; k < 14; k++) begin
      m = 8'($urandom);
      m[1:0] = 2'(1 + $urandom % 3);
      m[7:6] = 2'(1 + $urandom % 3);
      d = 8'($urandom);
      d2 = 8'($urandom);
      @(negedge clk) mode = m;
      gen(m, d);
      if (k % 3 == 0) begin
        gen(m, d2);
        write(d);
        run_q(1, 0, d2, "R2 R3 R4 R5 R8 random pair");
      end else begin
        write(d);
        run_q(0, 0, 8'h00, "R2 R3 R4 R5 random frame");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule